// File: doc/BRIEF.md
# Floating-Point Comparison Unit

This block is a purely combinational comparator for IEEE 754 binary operands. It answers one of three ordered questions about two operands: are they equal, is the first strictly smaller, or is the first smaller or equal. Either 32-bit single-precision or 64-bit double-precision operands can be compared through the same pair of operand buses.

The answer is intended for an integer destination register. It is therefore a full-width word whose value is exactly 0 or 1. A separate invalid-operation flag is raised according to the NaN rules below. In single-precision mode the operand sits in the low 32 bits of each bus, and whatever the upper half carries is disregarded.

Each supported format has its own lane, made of two operand classifiers and a sign/magnitude ordering stage. The precision select picks which lane's answer is used.

Top module: `fp_compare_unit`

## Requirements
- R1: With `pred_sel` = 2'b10 (equal), `result` is 1 when the two operands are numerically equal and 0 otherwise.
- R2: With `pred_sel` = 2'b01 (less-than), `result` is 1 when operand A is numerically smaller than operand B and 0 otherwise.
- R3: With `pred_sel` = 2'b00 (less-or-equal), `result` is 1 when operand A is smaller than or equal to operand B and 0 otherwise. The equal and less-than outcomes of one comparison are never both true.
- R4: With `pred_sel` = 2'b11 (unassigned), `result` is 0 and `invalid` is 0 for all operands, NaNs included.
- R5: Bits [63:1] of `result` are always 0.
- R6: Positive zero and negative zero compare as equal: equal gives 1, less-than gives 0, less-or-equal gives 1.
- R7: When either operand is a NaN (exponent all ones, significand nonzero), `result` is 0 for every predicate.
- R8: For less-than and less-or-equal, `invalid` is 1 exactly when at least one operand is a NaN of either kind.
- R9: For equal, `invalid` is 1 exactly when at least one operand is a signaling NaN (a NaN whose top significand bit is 0). Quiet NaNs (top significand bit 1) do not raise it.
- R10: With `is_double` = 0, both operands are read from bits [31:0] in the single layout (1 sign, 8 exponent, 23 significand bits), and bits [63:32] have no effect. With `is_double` = 1, the 64-bit layout (1 sign, 11 exponent, 52 significand bits) is used.
- R11: When both operands are negative, the operand with the larger magnitude is the smaller value. Any negative nonzero value is smaller than any positive value.
- R12: Infinities take part in ordering: negative infinity is below every finite value, positive infinity is above every finite value, and an infinity equals an infinity of the same sign.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 64 | First operand; single precision in bits [31:0] |
| opnd_b | input | 64 | Second operand; single precision in bits [31:0] |
| is_double | input | 1 | 1 selects the 64-bit format, 0 the 32-bit format |
| pred_sel | input | 2 | 00 less-or-equal, 01 less-than, 10 equal, 11 unassigned |
| result | output | 64 | Predicate outcome, 0 or 1 |
| invalid | output | 1 | Invalid-operation indication |

## Verification
The bench builds the unit with its default parameters: a 64-bit bus, an 8/23 single lane and an 11/52 double lane. With these values, subnormals, both zeros, both infinities and both NaN kinds are reachable in each format. The double-precision expectations come from native real comparisons. The single-precision expectations come from a signed integer key ordering. Neither follows the design's sign/magnitude structure. Random operands are biased toward zero and all-ones exponents, toward repeated operands and sign-flipped copies, and they carry random upper halves in single mode.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;
   typedef enum logic [1:0] {
      PRED_LE  = 2'b00,
      PRED_LT  = 2'b01,
      PRED_EQ  = 2'b10,
      PRED_RSV = 2'b11
   } fpcmp_pred_e;

   localparam int NUM_FMT = 2;
   localparam int FMT_SP  = 0;
   localparam int FMT_DP  = 1;
endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify #(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23,
   localparam int MAG_W = EXP_W + MAN_W,
   localparam int FMT_W = 1 + MAG_W
) (
   input  logic [FMT_W-1:0] opnd,
   output logic             sign,
   output logic [MAG_W-1:0] mag,
   output logic             is_zero,
   output logic             is_nan,
   output logic             is_snan
);
   logic [EXP_W-1:0] expo;
   logic [MAN_W-1:0] frac;

   always_comb begin
      sign    = opnd[FMT_W-1];
      mag     = opnd[MAG_W-1:0];
      expo    = opnd[MAG_W-1:MAN_W];
      frac    = opnd[MAN_W-1:0];
      is_zero = (mag == '0);
      is_nan  = (&expo) && (frac != '0);
      is_snan = is_nan && !frac[MAN_W-1];
   end

   // R7: a NaN can never also be classified as a zero
   always_comb begin
      assert_nan_not_zero_R7: assert (!(is_nan && is_zero));
   end
endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order #(
   parameter int MAG_W = 31
) (
   input  logic             sign_a,
   input  logic             sign_b,
   input  logic [MAG_W-1:0] mag_a,
   input  logic [MAG_W-1:0] mag_b,
   input  logic             zero_a,
   input  logic             zero_b,
   output logic             eq,
   output logic             lt
);
   logic mag_lt, mag_eq, both_zero;

   always_comb begin
      mag_lt    = (mag_a < mag_b);
      mag_eq    = (mag_a == mag_b);
      both_zero = zero_a && zero_b;
      eq        = both_zero || ((sign_a == sign_b) && mag_eq);
      if (both_zero)
         lt = 1'b0;
      else if (sign_a != sign_b)
         lt = sign_a;
      else if (sign_a)
         lt = !mag_lt && !mag_eq;
      else
         lt = mag_lt;
   end

   // R3: equal and less-than are mutually exclusive
   always_comb begin
      assert_eq_lt_exclusive_R3: assert (!(eq && lt));
   end
endmodule

// File: rtl/fpcmp_lane.sv
module fpcmp_lane #(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23,
   localparam int MAG_W = EXP_W + MAN_W,
   localparam int FMT_W = 1 + MAG_W
) (
   input  logic [FMT_W-1:0] opnd_a,
   input  logic [FMT_W-1:0] opnd_b,
   output logic             eq,
   output logic             lt,
   output logic             nan_any,
   output logic             snan_any
);
   logic             sgn_a, sgn_b, zr_a, zr_b, nan_a, nan_b, sn_a, sn_b;
   logic [MAG_W-1:0] mg_a, mg_b;

   fpcmp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls_a (
      .opnd(opnd_a), .sign(sgn_a), .mag(mg_a),
      .is_zero(zr_a), .is_nan(nan_a), .is_snan(sn_a));

   fpcmp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls_b (
      .opnd(opnd_b), .sign(sgn_b), .mag(mg_b),
      .is_zero(zr_b), .is_nan(nan_b), .is_snan(sn_b));

   fpcmp_order #(.MAG_W(MAG_W)) u_ord (
      .sign_a(sgn_a), .sign_b(sgn_b), .mag_a(mg_a), .mag_b(mg_b),
      .zero_a(zr_a), .zero_b(zr_b), .eq(eq), .lt(lt));

   assign nan_any  = nan_a || nan_b;
   assign snan_any = sn_a || sn_b;

   // R9: a signaling NaN is always reported as a NaN too
   always_comb begin
      assert_snan_is_nan_R9: assert (!snan_any || nan_any);
   end
endmodule

// File: rtl/fp_compare_unit.sv
module fp_compare_unit
   import fpcmp_pkg::*;
#(
   parameter int XLEN     = 64,
   parameter int SP_EXP_W = 8,
   parameter int SP_MAN_W = 23,
   parameter int DP_EXP_W = 11,
   parameter int DP_MAN_W = 52
) (
   input  logic [XLEN-1:0] opnd_a,
   input  logic [XLEN-1:0] opnd_b,
   input  logic            is_double,
   input  logic [1:0]      pred_sel,
   output logic [XLEN-1:0] result,
   output logic            invalid
);
   localparam int SP_W = 1 + SP_EXP_W + SP_MAN_W;
   localparam int DP_W = 1 + DP_EXP_W + DP_MAN_W;

   if (DP_W > XLEN) begin : g_chk_dp
      $error("double format wider than the operand bus");
   end
   if (SP_W > DP_W) begin : g_chk_sp
      $error("single format wider than double format");
   end

   logic [NUM_FMT-1:0] l_eq, l_lt, l_nan, l_snan;

   for (genvar g = 0; g < NUM_FMT; g++) begin : g_lane
      localparam int EW = (g == FMT_SP) ? SP_EXP_W : DP_EXP_W;
      localparam int MW = (g == FMT_SP) ? SP_MAN_W : DP_MAN_W;
      localparam int FW = 1 + EW + MW;
      fpcmp_lane #(.EXP_W(EW), .MAN_W(MW)) u_lane (
         .opnd_a  (opnd_a[FW-1:0]),
         .opnd_b  (opnd_b[FW-1:0]),
         .eq      (l_eq[g]),
         .lt      (l_lt[g]),
         .nan_any (l_nan[g]),
         .snan_any(l_snan[g]));
   end

   fpcmp_pred_e pred;
   logic        s_eq, s_lt, s_nan, s_snan, hit;

   always_comb begin
      pred    = fpcmp_pred_e'(pred_sel);
      s_eq    = is_double ? l_eq[FMT_DP]   : l_eq[FMT_SP];
      s_lt    = is_double ? l_lt[FMT_DP]   : l_lt[FMT_SP];
      s_nan   = is_double ? l_nan[FMT_DP]  : l_nan[FMT_SP];
      s_snan  = is_double ? l_snan[FMT_DP] : l_snan[FMT_SP];
      hit     = 1'b0;
      invalid = 1'b0;
      unique case (pred)
         PRED_EQ: begin hit = s_eq && !s_nan;          invalid = s_snan; end
         PRED_LT: begin hit = s_lt && !s_nan;          invalid = s_nan;  end
         PRED_LE: begin hit = (s_eq || s_lt) && !s_nan; invalid = s_nan; end
         default: begin hit = 1'b0;                    invalid = 1'b0;   end
      endcase
      result = {{(XLEN-1){1'b0}}, hit};
   end

   always_comb begin
      // R7: any NaN on the selected lane forces a zero answer
      assert_nan_false_R7: assert (!s_nan || result == '0);
      // R4: the unassigned predicate code is silent
      assert_rsv_silent_R4: assert (pred != PRED_RSV || (result == '0 && !invalid));
      // R9: a signaling NaN raises the flag for every assigned predicate
      assert_snan_flag_R9: assert (!s_snan || pred == PRED_RSV || invalid);
      // R5: only bit 0 of the answer can be set
      assert_upper_zero_R5: assert (result[XLEN-1:1] == '0);
   end
endmodule

// File: tb/tb_fp_compare_unit.sv
module tb_fp_compare_unit;
   logic        clk = 1'b0;
   logic [63:0] opnd_a, opnd_b, result;
   logic        is_double, invalid;
   logic [1:0]  pred_sel;
   int          checks = 0, fails = 0, cyc = 0;
   bit          done = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   fp_compare_unit dut (
      .opnd_a(opnd_a), .opnd_b(opnd_b), .is_double(is_double),
      .pred_sel(pred_sel), .result(result), .invalid(invalid));

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         fails++;
         $display("FAIL watchdog: run did not finish (actual cycle %0d, expected < 150000)", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   // behavioural reference: real numbers for double, signed key for single
   function automatic void ref_model(input logic [63:0] a, input logic [63:0] b,
                                     input logic dbl, input logic [1:0] p,
                                     output bit r, output bit inv);
      bit  an, bn, asn, bsn, e, l;
      real ra, rb;
      longint ka, kb;
      if (dbl) begin
         an  = (a[62:52] == 11'h7FF) && (a[51:0] != 0);
         bn  = (b[62:52] == 11'h7FF) && (b[51:0] != 0);
         asn = an && !a[51];
         bsn = bn && !b[51];
         ra = $bitstoreal(a);
         rb = $bitstoreal(b);
         e = (ra == rb);
         l = (ra < rb);
      end else begin
         an  = (a[30:23] == 8'hFF) && (a[22:0] != 0);
         bn  = (b[30:23] == 8'hFF) && (b[22:0] != 0);
         asn = an && !a[22];
         bsn = bn && !b[22];
         ka = a[31] ? -longint'(a[30:0]) : longint'(a[30:0]);
         kb = b[31] ? -longint'(b[30:0]) : longint'(b[30:0]);
         e = (ka == kb);
         l = (ka < kb);
      end
      r = 1'b0;
      inv = 1'b0;
      case (p)
         2'b10: begin r = e && !(an || bn);        inv = asn || bsn; end
         2'b01: begin r = l && !(an || bn);        inv = an || bn;   end
         2'b00: begin r = (e || l) && !(an || bn); inv = an || bn;   end
         default: begin r = 1'b0; inv = 1'b0; end
      endcase
   endfunction

   task automatic apply(input logic [63:0] a, input logic [63:0] b, input logic dbl,
                        input logic [1:0] p, input string tag);
      bit r, inv;
      @(negedge clk);
      opnd_a = a; opnd_b = b; is_double = dbl; pred_sel = p;
      ref_model(a, b, dbl, p, r, inv);
      @(posedge clk);
      checks++;
      if (result !== {63'b0, r}) begin
         fails++;
         $display("FAIL %s result a=%h b=%h dbl=%0b pred=%b actual=%h expected=%h",
                  tag, a, b, dbl, p, result, {63'b0, r});
      end
      checks++;
      if (invalid !== inv) begin
         fails++;
         $display("FAIL %s invalid a=%h b=%h dbl=%0b pred=%b actual=%0b expected=%0b",
                  tag, a, b, dbl, p, invalid, inv);
      end
   endtask

   function automatic logic [63:0] rnd_opnd(input logic dbl);
      logic [63:0] v;
      int          sel;
      v = {$urandom, $urandom};
      sel = $urandom % 8;
      if (dbl) begin
         if (sel == 0) v[62:52] = '0;
         if (sel == 1) v[62:52] = '1;
         if (sel == 2) v[51:0]  = '0;
         if (sel == 3) begin v[62:52] = '1; v[51:0] = '0; end
      end else begin
         if (sel == 0) v[30:23] = '0;
         if (sel == 1) v[30:23] = '1;
         if (sel == 2) v[22:0]  = '0;
         if (sel == 3) begin v[30:23] = '1; v[22:0] = '0; end
      end
      return v;
   endfunction

   initial begin
      opnd_a = '0; opnd_b = '0; is_double = 1'b0; pred_sel = 2'b10;
      // idle state: +0 vs +0, equal
      apply(64'h0, 64'h0, 1'b0, 2'b10, "R1 idle");
      // R1 R2 R3 single: 1.0 vs 2.0
      apply(64'h3F800000, 64'h40000000, 1'b0, 2'b10, "R1");
      apply(64'h3F800000, 64'h3F800000, 1'b0, 2'b10, "R1");
      apply(64'h3F800000, 64'h40000000, 1'b0, 2'b01, "R2");
      apply(64'h40000000, 64'h3F800000, 1'b0, 2'b01, "R2");
      apply(64'h3F800000, 64'h40000000, 1'b0, 2'b00, "R3");
      apply(64'h3F800000, 64'h3F800000, 1'b0, 2'b00, "R3");
      // R11 negatives: -1.0 vs -2.0
      apply(64'hBF800000, 64'hC0000000, 1'b0, 2'b01, "R11");
      apply(64'hC0000000, 64'hBF800000, 1'b0, 2'b01, "R11");
      apply(64'hBF800000, 64'h00000001, 1'b0, 2'b01, "R11");
      // R6 signed zeros, both formats
      apply(64'h00000000, 64'h80000000, 1'b0, 2'b10, "R6");
      apply(64'h80000000, 64'h00000000, 1'b0, 2'b01, "R6");
      apply(64'h00000000, 64'h80000000, 1'b0, 2'b00, "R6");
      apply(64'h8000000000000000, 64'h0, 1'b1, 2'b10, "R6");
      apply(64'h0, 64'h8000000000000000, 1'b1, 2'b01, "R6");
      // R7 R8 R9 NaNs
      apply(64'h7FC00000, 64'h3F800000, 1'b0, 2'b10, "R9 quiet");
      apply(64'h7F800001, 64'h3F800000, 1'b0, 2'b10, "R9 signaling");
      apply(64'h7FC00000, 64'h7FC00000, 1'b0, 2'b00, "R7");
      apply(64'h3F800000, 64'h7FC00000, 1'b0, 2'b01, "R8");
      apply(64'h7FF8000000000000, 64'h3FF0000000000000, 1'b1, 2'b00, "R8");
      apply(64'h7FF0000000000001, 64'h7FF0000000000001, 1'b1, 2'b10, "R9");
      // R4 unassigned code
      apply(64'h3F800000, 64'h3F800000, 1'b0, 2'b11, "R4");
      apply(64'h7F800001, 64'h3F800000, 1'b0, 2'b11, "R4");
      // R10 upper half ignored in single mode
      apply(64'hDEADBEEF_3F800000, 64'h12345678_3F800000, 1'b0, 2'b10, "R10");
      apply(64'hFFF00000_3F800000, 64'h00000000_40000000, 1'b0, 2'b01, "R10");
      apply(64'h7FF00000_00000000, 64'h00000000_3F800000, 1'b0, 2'b00, "R10");
      // R12 infinities, double and single
      apply(64'h7FF0000000000000, 64'h7FEFFFFFFFFFFFFF, 1'b1, 2'b00, "R12");
      apply(64'hFFF0000000000000, 64'h0, 1'b1, 2'b01, "R12");
      apply(64'h7F800000, 64'h7F800000, 1'b0, 2'b10, "R12");
      apply(64'h3FF0000000000000, 64'h4000000000000000, 1'b1, 2'b01, "R2");
      apply(64'h00000001, 64'h00000000, 1'b0, 2'b01, "R2");
      apply(64'h00000000, 64'h00000001, 1'b0, 2'b01, "R2");
      // random sweep; R5 (upper bits zero) is part of every result check
      for (int i = 0; i < 4000; i++) begin
         logic        dbl;
         logic [1:0]  p;
         logic [63:0] a, b;
         int          mode;
         dbl = 1'($urandom % 2);
         p = 2'($urandom % 4);
         a = rnd_opnd(dbl);
         mode = $urandom % 8;
         if (mode < 2)      b = a;
         else if (mode < 3) begin b = a; if (dbl) b[63] = ~b[63]; else b[31] = ~b[31]; end
         else               b = rnd_opnd(dbl);
         if (mode == 3 && !dbl) b[63:32] = ~b[63:32];
         case (p)
            2'b10:   apply(a, b, dbl, p, "R1/R5 random");
            2'b01:   apply(a, b, dbl, p, "R2/R5 random");
            2'b00:   apply(a, b, dbl, p, "R3/R5 random");
            default: apply(a, b, dbl, p, "R4/R5 random");
         endcase
      end
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule